// File: doc/BRIEF.md
# Configurable SPI Master Frame Engine

This block runs the master side of a four-wire serial link, one frame at a time. When it is idle and enabled and the transmit FIFO in front of it holds a word, it takes that word and pops the FIFO. It then drives SSEL low and toggles SCLK twice per bit. Data goes out on MOSI most significant bit first, and the bit returned on MISO is captured on the edge that the clock phase selects. When the frame ends, the received word is handed to the receive FIFO, right-justified. Frames run from 4 to 16 bits, set by a length-minus-one code.

The bit rate comes from an even prescaler followed by a second divider. One bit lasts P × (R+1) clock cycles, where P is the prescaler value with bit 0 cleared and R is the rate value. Because P is even, each half of a bit is exactly (P/2) × (R+1) cycles. A loopback mode feeds the engine's own MOSI line into its receive shifter. The engine samples the configuration at the start of each frame, so changes made during a frame take effect on the next one.

Top module: `spi_frame_master`

## Requirements
- R1: While `rst` is high and on the first cycle after it: `sclk`=0, `ssel_n`=1, `mosi`=0, `tx_pop`=0, `rx_push`=0, `rx_data`=0, `busy`=0.
- R2: A length code c from 3 to 15 gives c+1 bits per frame. Codes 0, 1 and 2 give 4 bits. A frame of N bits has exactly 2N SCLK transitions.
- R3: With P = `cfg_prescale` with bit 0 forced to 0 (and P=0 taken as 2), and R = `cfg_rate`, SCLK transitions are spaced H = (P/2)·(R+1) cycles apart. The first transition comes H cycles after `ssel_n` falls.
- R4: Between frames `ssel_n`=1 and `sclk` follows `cfg_cpol` one cycle later. During a frame `ssel_n`=0. The last transition returns `sclk` to the frame's idle level in the same cycle that `ssel_n` rises.
- R5: With `cfg_cpha`=0, MISO is captured on odd transitions (1, 3, …) and MOSI advances on even transitions below 2N. With `cfg_cpha`=1, MISO is captured on even transitions and MOSI advances on odd transitions from 3 on.
- R6: From the first cycle of a frame MOSI shows bit N−1 of the transmit word, then the lower bits in order. Bits at positions N and above are ignored.
- R7: `rx_push` is high for one cycle, the cycle after the last transition. `rx_data` then holds the N captured bits, right-justified with zeros above, and keeps that value until the next push.
- R8: When `cfg_loopback`=1 the receive shifter reads MOSI instead of `miso`, so the received word equals the transmitted word reduced to N bits.
- R9: A frame starts (`ssel_n` falls, `tx_pop` high for one cycle) the cycle after a clock edge at which the engine is idle, `cfg_enable`=1 and `tx_empty`=0. There is at least one idle cycle between frames, and no frame starts while `cfg_enable`=0.
- R10: `busy` is 1 in the cycle after an edge at which a frame is running (or starting) or `tx_empty` is 0, and 0 otherwise.
- R11: Length, polarity, phase, loopback, prescale and rate are sampled when a frame starts. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_len_code | input | 4 | Bits per frame minus one |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_loopback | input | 1 | Receive from own MOSI instead of MISO |
| cfg_prescale | input | 8 | Even prescale divider (bit 0 ignored) |
| cfg_rate | input | 8 | Second divider value minus one |
| tx_empty | input | 1 | Transmit FIFO has no word |
| tx_data | input | 16 | Head word of the transmit FIFO, right-justified |
| tx_pop | output | 1 | Removes the head word of the transmit FIFO |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_data | output | 16 | Last received word, right-justified |
| miso | input | 1 | Serial input from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output to the slave |
| ssel_n | output | 1 | Slave select, active low |
| busy | output | 1 | Frame in progress or transmit word pending |

## Verification
The assertions assume the transmit FIFO keeps its head word stable and treats `tx_pop` as its removal strobe. They also assume the receive side accepts every `rx_push` without back-pressure, because the engine has no way to wait. The stimulus changes every input half a cycle away from the active edge. A FIFO model in the stimulus removes the head word only on `tx_pop` and adds words only between edges. The stimulus also changes configuration in the middle of frames, since the block must tolerate that.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  localparam int unsigned MAX_BITS = 16;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned NB_W     = $clog2(MAX_BITS) + 1;

  // configuration captured at frame start
  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              loopback;
    logic [NB_W-1:0]   nbits;
    logic [DIV_W-2:0]  half_p;
    logic [DIV_W-1:0]  rate;
  } frame_cfg_t;

  // bits per frame from the length code; codes below 3 give the minimum
  function automatic logic [NB_W-1:0] frame_bits(input logic [CODE_W-1:0] code);
    if (code < CODE_W'(3)) frame_bits = NB_W'(4);
    else                   frame_bits = NB_W'(code) + NB_W'(1);
  endfunction

  // half of the even prescaler, never below one cycle
  function automatic logic [DIV_W-2:0] half_prescale(input logic [DIV_W-1:0] ps);
    if (ps[DIV_W-1:1] == '0) half_prescale = (DIV_W-1)'(1);
    else                     half_prescale = ps[DIV_W-1:1];
  endfunction

endpackage

// File: rtl/spi_fm_rate.sv
module spi_fm_rate #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-2:0] half_p,
  input  logic [DIV_W-1:0] rate,
  output logic             edge_tick
);

  logic [DIV_W-2:0] pcnt;
  logic [DIV_W-1:0] dcnt;
  logic             p_wrap;
  logic             d_wrap;

  assign p_wrap    = (pcnt == half_p - (DIV_W-1)'(1));
  assign d_wrap    = (dcnt == rate);
  assign edge_tick = run && p_wrap && d_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (p_wrap) begin
      pcnt <= '0;
      if (d_wrap) dcnt <= '0;
      else        dcnt <= dcnt + DIV_W'(1);
    end else begin
      pcnt <= pcnt + (DIV_W-1)'(1);
    end
  end

endmodule

// File: rtl/spi_fm_seq.sv
module spi_fm_seq
  import spi_fm_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  frame_cfg_t        cfg_now,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  input  logic              edge_tick,
  output logic              active,
  output frame_cfg_t        cfg_lat,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  output logic              ssel_n,
  output logic              busy
);

  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam int unsigned EC_W  = NB_W + 1;

  logic [EC_W-1:0]   ecnt;
  logic [EC_W-1:0]   ecnt_nx;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] tword;
  logic [DATA_W-1:0] rsh;
  logic [DATA_W-1:0] rsh_nx;
  logic              rx_in;
  logic              start;
  logic              capture;
  logic              last_edge;
  logic [IDX_W-1:0]  first_idx;

  assign start     = !active && enable && !tx_empty;
  assign ecnt_nx   = ecnt + EC_W'(1);
  assign capture   = ecnt_nx[0] ^ cfg_lat.cpha;
  assign last_edge = edge_tick && (ecnt_nx == {cfg_lat.nbits, 1'b0});
  assign rx_in     = cfg_lat.loopback ? mosi : miso;
  assign rsh_nx    = {rsh[DATA_W-2:0], rx_in};
  assign first_idx = IDX_W'(cfg_now.nbits - NB_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cfg_lat <= '0;
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      rx_data <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      ssel_n  <= 1'b1;
      busy    <= 1'b0;
      ecnt    <= '0;
      bidx    <= '0;
      tword   <= '0;
      rsh     <= '0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      if (!active) begin
        sclk   <= cfg_now.cpol;
        ssel_n <= 1'b1;
        mosi   <= 1'b0;
        if (start) begin
          active  <= 1'b1;
          cfg_lat <= cfg_now;
          tx_pop  <= 1'b1;
          ssel_n  <= 1'b0;
          tword   <= tx_data;
          bidx    <= first_idx;
          mosi    <= tx_data[first_idx];
          ecnt    <= '0;
          rsh     <= '0;
        end
      end else if (edge_tick) begin
        sclk <= ~sclk;
        ecnt <= ecnt_nx;
        if (capture) begin
          rsh <= rsh_nx;
        end else if (ecnt_nx != EC_W'(1) && !last_edge) begin
          bidx <= bidx - IDX_W'(1);
          mosi <= tword[bidx - IDX_W'(1)];
        end
        if (last_edge) begin
          active  <= 1'b0;
          ssel_n  <= 1'b1;
          rx_push <= 1'b1;
          rx_data <= capture ? rsh_nx : rsh;
        end
      end
      busy <= start || (active && !last_edge) || !tx_empty;
    end
  end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int unsigned DATA_W = MAX_BITS,
  parameter int unsigned LEN_W  = CODE_W,
  parameter int unsigned DW     = DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [LEN_W-1:0]  cfg_len_code,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_loopback,
  input  logic [DW-1:0]     cfg_prescale,
  input  logic [DW-1:0]     cfg_rate,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ssel_n,
  output logic              busy
);

  frame_cfg_t cfg_now;
  frame_cfg_t cfg_lat;
  logic       active;
  logic       edge_tick;

  always_comb begin
    cfg_now          = '0;
    cfg_now.cpol     = cfg_cpol;
    cfg_now.cpha     = cfg_cpha;
    cfg_now.loopback = cfg_loopback;
    cfg_now.nbits    = frame_bits(CODE_W'(cfg_len_code));
    cfg_now.half_p   = half_prescale(DIV_W'(cfg_prescale));
    cfg_now.rate     = DIV_W'(cfg_rate);
  end

  spi_fm_rate #(.DIV_W(DIV_W)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .run       (active),
    .half_p    (cfg_lat.half_p),
    .rate      (cfg_lat.rate),
    .edge_tick (edge_tick)
  );

  spi_fm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (cfg_enable),
    .cfg_now   (cfg_now),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .miso      (miso),
    .edge_tick (edge_tick),
    .active    (active),
    .cfg_lat   (cfg_lat),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .rx_data   (rx_data),
    .sclk      (sclk),
    .mosi      (mosi),
    .ssel_n    (ssel_n),
    .busy      (busy)
  );

endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk (
  input logic clk,
  input logic rst,
  input logic cfg_enable,
  input logic cfg_cpol,
  input logic tx_empty,
  input logic tx_pop,
  input logic rx_push,
  input logic sclk,
  input logic ssel_n,
  input logic busy
);

  logic       sclk_d;
  logic       ssel_d;
  logic [6:0] n_edges;

  // transitions seen while the select line was low
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      ssel_d  <= 1'b1;
      n_edges <= '0;
    end else begin
      sclk_d <= sclk;
      ssel_d <= ssel_n;
      if (tx_pop)                       n_edges <= '0;
      else if (sclk != sclk_d && !ssel_d) n_edges <= n_edges + 7'd1;
    end
  end

  // R2: the push follows an even number of transitions, 8 to 32
  p_frame_edges_r2: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (sclk != sclk_d) && n_edges[0] && (n_edges >= 7'd7) && (n_edges <= 7'd31));

  // R4: between frames the clock sits at the configured idle level
  p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
    (ssel_n && $past(ssel_n) && !$past(rst)) |-> sclk == $past(cfg_cpol));

  // R7: a push marks the end of a frame
  p_push_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> ssel_n && !$past(ssel_n));

  // R9: a pop lasts one cycle and only follows an allowed start
  p_pop_single_r9: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> !tx_pop);

  p_pop_cause_r9: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(cfg_enable && !tx_empty && ssel_n));

  // R10: busy covers every active frame
  p_busy_frame_r10: assert property (@(posedge clk) disable iff (rst)
    !ssel_n |-> busy);

endmodule

bind spi_frame_master spi_fm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_enable (cfg_enable),
  .cfg_cpol   (cfg_cpol),
  .tx_empty   (tx_empty),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .sclk       (sclk),
  .ssel_n     (ssel_n),
  .busy       (busy)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [3:0]  cfg_len_code = 4'd7;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic        cfg_loopback = 1'b0;
  logic [7:0]  cfg_prescale = 8'd2;
  logic [7:0]  cfg_rate = 8'd0;
  logic        tx_empty = 1'b1;
  logic [15:0] tx_data = 16'd0;
  logic        miso = 1'b0;
  logic        tx_pop, rx_push, sclk, mosi, ssel_n, busy;
  logic [15:0] rx_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  string phase = "R1";

  logic [15:0] txq[$];
  logic [15:0] got[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_master u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_len_code(cfg_len_code),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_loopback(cfg_loopback),
    .cfg_prescale(cfg_prescale), .cfg_rate(cfg_rate), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .miso(miso), .sclk(sclk), .mosi(mosi), .ssel_n(ssel_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (phase %s) %s: actual=%0h expected=%0h t=%0t",
               req, phase, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          e_act, e_sclk, e_ssel, e_mosi, e_pop, e_push, e_busy;
  logic [15:0] e_rx;
  int          m_t, m_h, m_n, m_bit, m_k;
  bit          m_cpha, m_lb;
  logic [15:0] m_word, m_rx;

  always @(posedge clk) begin
    if (rst) begin
      e_act = 0; e_sclk = 0; e_ssel = 1; e_mosi = 0;
      e_pop = 0; e_push = 0; e_busy = 0; e_rx = 16'd0;
    end else begin
      e_pop = 0; e_push = 0;
      if (!e_act) begin
        e_sclk = cfg_cpol; e_ssel = 1; e_mosi = 0;
        if (cfg_enable && txq.size() > 0) begin
          e_act  = 1; e_ssel = 0; e_pop = 1;
          m_n    = (cfg_len_code < 3) ? 4 : int'(cfg_len_code) + 1;
          m_h    = ((cfg_prescale >> 1) == 0 ? 1 : int'(cfg_prescale >> 1)) * (int'(cfg_rate) + 1);
          m_cpha = cfg_cpha; m_lb = cfg_loopback;
          m_word = txq[0]; m_bit = m_n - 1; e_mosi = m_word[m_bit];
          m_t = 0; m_rx = 16'd0;
        end
      end else begin
        m_t++;
        if (m_t % m_h == 0) begin
          m_k = m_t / m_h;
          e_sclk = !e_sclk;
          if (((m_k % 2) == 1) == (m_cpha == 0))
            m_rx = {m_rx[14:0], (m_lb ? e_mosi : miso)};
          else if (m_k > 1 && m_k < 2*m_n) begin
            m_bit--; e_mosi = m_word[m_bit];
          end
          if (m_k == 2*m_n) begin
            e_act = 0; e_ssel = 1; e_push = 1; e_rx = m_rx;
          end
        end
      end
      e_busy = e_act || (txq.size() > 0);
    end
  end

  // compare every cycle, collect receive words, serve the transmit FIFO
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(sclk == e_sclk, "R3", "sclk", sclk, e_sclk);
      chk(ssel_n == e_ssel, "R4", "ssel_n", ssel_n, e_ssel);
      chk(mosi == e_mosi, "R6", "mosi", mosi, e_mosi);
      chk(tx_pop == e_pop, "R9", "tx_pop", tx_pop, e_pop);
      chk(rx_push == e_push, "R7", "rx_push", rx_push, e_push);
      chk(rx_data == e_rx, "R7", "rx_data", rx_data, e_rx);
      chk(busy == e_busy, "R10", "busy", busy, e_busy);
      if (rx_push) got.push_back(rx_data);
      if (tx_pop && txq.size() > 0) void'(txq.pop_front());
    end
    #3;
    tx_empty = (txq.size() == 0);
    tx_data  = (txq.size() > 0) ? txq[0] : 16'd0;
    miso     = 1'($urandom);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put(input logic [15:0] w);
    @(negedge clk); #1;
    txq.push_back(w);
  endtask

  task automatic setcfg(input logic [3:0] len, input bit pol, input bit pha,
                        input bit lb, input logic [7:0] ps, input logic [7:0] rt);
    @(negedge clk); #1;
    cfg_len_code = len; cfg_cpol = pol; cfg_cpha = pha;
    cfg_loopback = lb; cfg_prescale = ps; cfg_rate = rt;
  endtask

  task automatic drain();
    do @(negedge clk); while (busy || txq.size() != 0 || !ssel_n);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_rx(input string req, input logic [15:0] exp);
    if (got.size() == 0) chk(1'b0, req, "missing rx word", 0, exp);
    else begin
      logic [15:0] w;
      w = got.pop_front();
      chk(w == exp, req, "rx word", w, exp);
    end
  endtask

  initial begin
    // R1: reset values, during reset and right after release
    repeat (3) @(negedge clk);
    chk({sclk, ssel_n, mosi, tx_pop, rx_push, busy} == 6'b010000, "R1",
        "reset outputs", {sclk, ssel_n, mosi, tx_pop, rx_push, busy}, 6'b010000);
    chk(rx_data == 16'd0, "R1", "reset rx_data", rx_data, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(ssel_n && !busy && !tx_pop, "R1", "first cycle after reset",
        {ssel_n, busy, tx_pop}, 3'b100);

    // R9: disabled engine must not start even with data waiting
    phase = "R9";
    put(16'h00A5);
    repeat (40) @(negedge clk);
    chk(ssel_n && txq.size() == 1, "R9", "no start while disabled", ssel_n, 1);

    // R8: loopback returns the transmitted word
    phase = "R8";
    setcfg(4'd7, 1'b0, 1'b0, 1'b1, 8'd2, 8'd0);
    cfg_enable = 1'b1;
    put(16'h003C);
    drain();
    expect_rx("R8", 16'h00A5);
    expect_rx("R8", 16'h003C);

    // R6: upper bits of a short word are ignored
    phase = "R6";
    setcfg(4'd3, 1'b1, 1'b1, 1'b1, 8'd4, 8'd1);
    put(16'hFFF6);
    drain();
    expect_rx("R6", 16'h0006);

    // R2: illegal codes act as 4-bit frames
    phase = "R2";
    setcfg(4'd1, 1'b0, 1'b1, 1'b1, 8'd2, 8'd0);
    put(16'h123B);
    drain();
    expect_rx("R2", 16'h000B);

    // R2 / R5: sweep all codes, phases and polarities with live MISO
    for (int c = 0; c < 16; c++) begin
      phase = "R5";
      setcfg(4'(c), 1'(c >> 1), 1'(c), 1'b0, (c % 3 == 0) ? 8'd6 : 8'd2, 8'(c % 2));
      put(16'(16'hC3A5 ^ (c * 16'h1111)));
      put(16'(16'h5A0F + c));
      drain();
    end
    got.delete();

    // R3: odd and zero prescale values
    phase = "R3";
    setcfg(4'd9, 1'b1, 1'b0, 1'b0, 8'd5, 8'd2);
    put(16'h02D3);
    drain();
    setcfg(4'd5, 1'b0, 1'b0, 1'b1, 8'd0, 8'd3);
    put(16'h0029);
    drain();
    got.delete();

    // R11: configuration changes during a frame are not applied to it
    phase = "R11";
    setcfg(4'd15, 1'b0, 1'b0, 1'b1, 8'd4, 8'd1);
    put(16'hB7E1);
    repeat (12) @(negedge clk);
    setcfg(4'd3, 1'b1, 1'b1, 1'b0, 8'd10, 8'd4);
    drain();
    expect_rx("R11", 16'hB7E1);

    // R9 / R10: back-to-back words keep the idle gap; busy falls after
    phase = "R10";
    setcfg(4'd4, 1'b0, 1'b1, 1'b0, 8'd2, 8'd0);
    put(16'h0011);
    put(16'h0012);
    put(16'h0013);
    drain();
    chk(!busy, "R10", "busy after drain", busy, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule